// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is one logic slice of a small programmable logic device. It receives 36 routed input signals and makes both the true and the inverted form of each, giving 72 literals. There are 86 AND terms, and configuration bits select which literals each term uses. A steering map then builds each of 16 sum outputs as the OR of any chosen subset of those terms. One term may drive several sums at the same time, and each sum may take from zero to sixteen terms. The path from the inputs to the sums is combinational, with no pipeline register.

Configuration enters over a one-bit serial chain into a shadow image. The live image changes only when a commit strobe arrives. A commit is refused when the shadow steering map gives any sum more than sixteen terms; an error flag then reports the refusal. The data path uses valid/ready. The block holds no data, so valid and ready pass straight through. A sum is meaningful whenever `out_valid` is high. When downstream drops `out_ready`, upstream sees `in_ready` low and must hold `in_data` steady.

Top module: `pla_logic_block`

## Requirements
- R1: While and after reset, until the first accepted commit, the live image is all zeros, so `out_sum` is 0 for any input, and `cfg_err` is 0.
- R2: Literal 2*i of a term is input i and literal 2*i+1 is the inverse of input i. A term is the AND of its enabled literals, and a sum is the OR of the terms steered to it. `out_sum` follows `in_data` in the same cycle.
- R3: A term with no enabled literal evaluates to 1.
- R4: A term that enables both literals of one input evaluates to 0.
- R5: A sum with no steered term evaluates to 0.
- R6: One term steered to several sums drives all of them at once.
- R7: The image is 7568 bits wide, ordered {AND mask, steering}. The mask bit for term t, literal l sits at 1376 + t*72 + l, and the steering bit for sum o, term t sits at o*86 + t. Bits enter MSB first, one per clock, and only while `cfg_load` is 1. Clocks with `cfg_load` at 0 leave the shadow unchanged.
- R8: The live image changes only on a clock edge where `cfg_commit` is 1. Shifting does not alter `out_sum`.
- R9: On a commit where the shadow steering gives any sum more than 16 terms, the live image keeps its value and `cfg_err` becomes 1. A commit where every sum has at most 16 terms (16 is allowed) loads the image and clears `cfg_err`.
- R10: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Shift enable for the serial chain |
| cfg_sdi | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | Copy the shadow image to the live image |
| cfg_err | output | 1 | Last commit refused due to a steering over-limit |
| in_valid | input | 1 | Input data valid |
| in_ready | output | 1 | Block can take input (follows out_ready) |
| in_data | input | 36 | Routed input signals |
| out_valid | output | 1 | Sum outputs valid |
| out_ready | input | 1 | Downstream ready |
| out_sum | output | 16 | Sum-of-products outputs |

## Verification
The assertions assume that `cfg_load` and `cfg_commit` are driven to known levels from the first clock. They also assume that `in_data` changes only when the block is not committing, so a change in the sums can be traced to one cause. The bench changes stimulus only on the falling edge and never raises a commit in the same cycle as a new input vector. It samples the sums a short delay after each input change. Every configuration shifts a full image, so the shadow never holds a partial image at a commit.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Default geometry of one logic slice
  localparam int unsigned DEF_N_IN   = 36;
  localparam int unsigned DEF_N_PT   = 86;
  localparam int unsigned DEF_N_OUT  = 16;
  localparam int unsigned DEF_MAX_PT = 16;

  function automatic int unsigned lit_count(input int unsigned n_in);
    return 2 * n_in;
  endfunction

  function automatic int unsigned mask_width(input int unsigned n_in, input int unsigned n_pt);
    return n_pt * lit_count(n_in);
  endfunction

  function automatic int unsigned steer_width(input int unsigned n_out, input int unsigned n_pt);
    return n_out * n_pt;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned IMG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             sdi,
  input  logic             commit,
  input  logic             reject,
  output logic [IMG_W-1:0] shadow,
  output logic [IMG_W-1:0] active,
  output logic             err
);
  // Shadow chain: bits enter at the LSB, so the first bit ends at the MSB
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (load) begin
      shadow <= {shadow[IMG_W-2:0], sdi};
    end
  end

  // Live image and commit status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      err    <= 1'b0;
    end else if (commit) begin
      if (reject) begin
        err <= 1'b1;
      end else begin
        active <= shadow;
        err    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pla_limit_check.sv
module pla_limit_check #(
  parameter int unsigned N_PT   = 86,
  parameter int unsigned N_OUT  = 16,
  parameter int unsigned MAX_PT = 16
) (
  input  logic [N_OUT*N_PT-1:0] steer,
  output logic                  over
);
  localparam int unsigned CNT_W = $clog2(N_PT + 1);

  logic [N_OUT-1:0] row_over;

  for (genvar o = 0; o < N_OUT; o++) begin : g_row
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int t = 0; t < N_PT; t++) begin
        cnt = cnt + CNT_W'(steer[o*N_PT + t]);
      end
    end
    assign row_over[o] = (32'(cnt) > MAX_PT);
  end

  assign over = |row_over;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 86
) (
  input  logic [N_IN-1:0]        x,
  input  logic [N_PT*2*N_IN-1:0] mask,
  output logic [N_PT-1:0]        term
);
  localparam int unsigned N_LIT = 2 * N_IN;

  logic [N_LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = x[i];
    assign lit[2*i+1] = ~x[i];
  end

  // A disabled literal reads as 1; an empty term is therefore 1
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] sel;
    assign sel     = mask[t*N_LIT +: N_LIT];
    assign term[t] = &(lit | ~sel);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = 86,
  parameter int unsigned N_OUT = 16
) (
  input  logic [N_PT-1:0]       term,
  input  logic [N_OUT*N_PT-1:0] steer,
  output logic [N_OUT-1:0]      sum
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum[o] = |(term & steer[o*N_PT +: N_PT]);
  end
endmodule

// File: rtl/pla_logic_block.sv
module pla_logic_block
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = DEF_N_IN,
  parameter int unsigned N_PT   = DEF_N_PT,
  parameter int unsigned N_OUT  = DEF_N_OUT,
  parameter int unsigned MAX_PT = DEF_MAX_PT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_sdi,
  input  logic             cfg_commit,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_IN-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_OUT-1:0] out_sum
);
  localparam int unsigned MASK_W  = mask_width(N_IN, N_PT);
  localparam int unsigned STEER_W = steer_width(N_OUT, N_PT);
  localparam int unsigned IMG_W   = MASK_W + STEER_W;

  logic [IMG_W-1:0] shadow_img;
  logic [IMG_W-1:0] active_img;
  logic             over;
  logic [N_PT-1:0]  term;

  pla_cfg_chain #(.IMG_W(IMG_W)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .sdi    (cfg_sdi),
    .commit (cfg_commit),
    .reject (over),
    .shadow (shadow_img),
    .active (active_img),
    .err    (cfg_err)
  );

  pla_limit_check #(.N_PT(N_PT), .N_OUT(N_OUT), .MAX_PT(MAX_PT)) u_limit (
    .steer (shadow_img[STEER_W-1:0]),
    .over  (over)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .x    (in_data),
    .mask (active_img[IMG_W-1:STEER_W]),
    .term (term)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .term  (term),
    .steer (active_img[STEER_W-1:0]),
    .sum   (out_sum)
  );

  // No storage on the data path: the handshake passes straight through
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/pla_logic_block_chk.sv
module pla_logic_block_chk #(
  parameter int unsigned IMG_W = 8,
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_commit,
  input logic             cfg_err,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N_IN-1:0]  in_data,
  input logic [N_OUT-1:0] out_sum,
  input logic [IMG_W-1:0] shadow_img,
  input logic [IMG_W-1:0] active_img,
  input logic             over
);
  // R10
  handshake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(shadow_img));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(active_img));

  // R9
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_commit && over) |=> ($stable(active_img) && cfg_err));

  // R9
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_commit && !over) |=> ((active_img == $past(shadow_img)) && !cfg_err));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(cfg_err));

  // R2
  comb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_commit) && $stable(in_data)) |-> $stable(out_sum));
endmodule

bind pla_logic_block pla_logic_block_chk #(
  .IMG_W (IMG_W),
  .N_IN  (N_IN),
  .N_OUT (N_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .cfg_commit (cfg_commit),
  .cfg_err    (cfg_err),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .in_data    (in_data),
  .out_sum    (out_sum),
  .shadow_img (shadow_img),
  .active_img (active_img),
  .over       (over)
);

// File: tb/sim_pla_logic_block.sv
`timescale 1ns/1ps
module sim_pla_logic_block;
  localparam int N_IN    = 36;
  localparam int N_PT    = 86;
  localparam int N_OUT   = 16;
  localparam int N_LIT   = 2 * N_IN;
  localparam int STEER_W = N_OUT * N_PT;
  localparam int IMG_W   = N_PT * N_LIT + STEER_W;
  localparam int N_VEC   = 6;

  // {in_data, expected out_sum} for configuration A
  localparam logic [51:0] VEC [0:N_VEC-1] = '{
    {36'h0_0000_0000, 16'h004A},
    {36'h0_0000_0003, 16'h000B},
    {36'h8_0000_0000, 16'h004E},
    {36'h8_0000_0005, 16'h0008},
    {36'hF_FFFF_FFFF, 16'h000B},
    {36'h0_0000_0001, 16'h0008}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_load = 1'b0;
  logic             cfg_sdi = 1'b0;
  logic             cfg_commit = 1'b0;
  logic             cfg_err;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [N_IN-1:0]  in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [N_OUT-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [IMG_W-1:0] img;

  always #10 clk = ~clk;

  pla_logic_block u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sdi(cfg_sdi),
    .cfg_commit(cfg_commit), .cfg_err(cfg_err), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_lit(input int t, input int l);
    img[STEER_W + t*N_LIT + l] = 1'b1;
  endtask

  task automatic set_steer(input int o, input int t);
    img[o*N_PT + t] = 1'b1;
  endtask

  task automatic shift_img();
    for (int k = IMG_W - 1; k >= 0; k--) begin
      cfg_load = 1'b1;
      cfg_sdi  = img[k];
      @(negedge clk);
    end
    cfg_load = 1'b0;
    cfg_sdi  = 1'b0;
  endtask

  task automatic do_commit();
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic apply(input logic [N_IN-1:0] d);
    in_data = d;
    #1;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    apply('1);
    check("R1 sums in reset", 32'(out_sum), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    apply('1);
    check("R1 sums after reset", 32'(out_sum), 32'h0);
    check("R1 err after reset", 32'(cfg_err), 32'h0);

    // R10: handshake pass-through
    in_valid = 1'b1; out_ready = 1'b0; #1;
    check("R10 valid", 32'(out_valid), 32'h1);
    check("R10 ready low", 32'(in_ready), 32'h0);
    in_valid = 1'b0; out_ready = 1'b1; #1;
    check("R10 valid low", 32'(out_valid), 32'h0);
    check("R10 ready", 32'(in_ready), 32'h1);
    in_valid = 1'b1;

    // Configuration A
    img = '0;
    set_lit(0, 0); set_lit(0, 2);          // T0 = in0 & in1
    set_lit(1, 1);                         // T1 = ~in0
    set_lit(2, 70); set_lit(2, 5);         // T2 = in35 & ~in2
    set_lit(4, 6); set_lit(4, 7);          // T4 = in3 & ~in3
    set_steer(0, 0);
    set_steer(1, 0); set_steer(1, 1);
    set_steer(2, 2);
    set_steer(3, 3);                       // T3 has no literal
    set_steer(5, 4);
    set_steer(6, 1); set_steer(6, 2);
    apply('1);
    shift_img();
    check("R8 no change while shifting", 32'(out_sum), 32'h0);
    do_commit();
    check("R9 err after good commit", 32'(cfg_err), 32'h0);

    // R2: table walk
    for (int v = 0; v < N_VEC; v++) begin
      apply(VEC[v][51:16]);
      check("R2 sum table", 32'(out_sum), 32'(VEC[v][15:0]));
    end

    apply(36'h0_0000_0003);
    check("R3 empty term is 1", 32'(out_sum[3]), 32'h1);
    check("R4 contradictory term", 32'(out_sum[5]), 32'h0);
    check("R5 unsteered sum", 32'(out_sum[4]), 32'h0);
    check("R6 shared term", 32'({out_sum[1], out_sum[0]}), 32'h3);

    // Configuration B: sum 7 takes 17 terms, so the commit is refused
    img = '0;
    for (int t = 0; t < 17; t++) set_steer(7, t);
    shift_img();
    do_commit();
    check("R9 err on over-limit", 32'(cfg_err), 32'h1);
    apply(36'h0_0000_0003);
    check("R9 image kept", 32'(out_sum), 32'h000B);

    // Configuration C: exactly 16 terms on sum 7
    img = '0;
    for (int t = 0; t < 16; t++) set_steer(7, t);
    shift_img();
    apply(36'h0_0000_0003);
    check("R8 pre-commit image", 32'(out_sum), 32'h000B);
    do_commit();
    check("R9 16 terms accepted", 32'(cfg_err), 32'h0);
    apply(36'h0_0000_0000);
    check("R9 new image live", 32'(out_sum), 32'h0080);

    // R7: sdi ignored while cfg_load is low
    cfg_sdi = 1'b1;
    @(negedge clk);
    cfg_sdi = 1'b0;
    do_commit();
    apply(36'h0_0000_0000);
    check("R7 no shift without load", 32'(out_sum), 32'h0080);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule